// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block produces the partial-store lane mask used at the two ends of a pixel row. The caller presents a start address and an end address, an element size (8, 16 or 32 bits), a byte-order select, a flag-update enable and a 32-bit addressing flag, together with a one-cycle input strobe. One clock later the block returns a lane mask of 8, 4 or 2 bits, zero-extended to 64 bits. For the first address the mask covers the lanes from the addressed element to the end of its 8-byte block. When both addresses fall in the same 8-byte block, this mask is intersected with the mask for the end address.

When flag update is enabled, the block also subtracts the end address from the start address. It records negative, zero, overflow and borrow flags for the low 32 bits and for the full 64 bits. The caller writes the mask and the flags back to its own register files.

Top module: `edge_mask_unit`

## Requirements
- R1: With `elem_size`=2'b00 (and also the unused code 2'b11) and `little_end`=0, address bits [2:0] value k give a start mask of 8'hFF>>k and an end mask of 8'hFF<<(7-k) truncated to 8 bits (8'h80 for k=0 up to 8'hFF for k=7).
- R2: With `elem_size`=2'b00 and `little_end`=1, the start mask is 8'hFF<<k truncated to 8 bits (8'hFF, 8'hFE, ..., 8'h80) and the end mask is 8'hFF>>(7-k) (8'h01, 8'h03, ..., 8'hFF).
- R3: With `elem_size`=2'b01, address bits [2:1] value k give 4-bit masks: big-endian start 4'hF>>k and end 8,C,E,F; little-endian start F,E,C,8 and end 1,3,7,F.
- R4: With `elem_size`=2'b10, address bit 2 gives 2-bit masks: big-endian start 3,1 and end 2,3; little-endian start 3,2 and end 1,3.
- R5: If the two addresses agree in every bit above bit 2, `mask_out` is the start mask AND the end mask. Otherwise `mask_out` is the start mask alone.
- R6: With `addr32`=1, bits [63:32] of both addresses play no part in the same-block compare of R5.
- R7: On a strobe with `cc_en`=1, `cc_icc` and `cc_xcc` take the flags {N,Z,V,C} (bit 3 down to bit 0) of `addr_a - addr_b` on bits [31:0] and on the full 64 bits. C means borrow. Both flag sets come from the untruncated addresses, whatever `addr32` is.
- R8: `cc_valid` rises one cycle after a strobe only when `cc_en`=1. A strobe with `cc_en`=0 leaves `cc_icc` and `cc_xcc` unchanged.
- R9: `out_valid` follows `in_valid` with one cycle of latency. `mask_out` updates only on a strobe, and its bits above the lane count are zero.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| addr_a | input | 64 | Row start address |
| addr_b | input | 64 | Row end address |
| elem_size | input | 2 | 00: 8-bit, 01: 16-bit, 10: 32-bit, 11: as 8-bit |
| little_end | input | 1 | Little-endian lane order |
| cc_en | input | 1 | Compute and publish flags |
| addr32 | input | 1 | 32-bit address mode for the block compare |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| mask_out | output | 64 | Zero-extended lane mask |
| cc_valid | output | 1 | Flags updated this cycle |
| cc_icc | output | 4 | {N,Z,V,C} of the 32-bit difference |
| cc_xcc | output | 4 | {N,Z,V,C} of the 64-bit difference |

## Verification
Two functions can act in the same cycle: the mask selection under 32-bit addressing, which truncates the addresses, and the flag computation, which does not. Directed vectors provoke the conflict with addresses whose upper words differ and whose lower words share a block. The mask must then be the intersection, `cc_icc` must report a zero difference, and `cc_xcc` must not. A behavioural lane model in the bench judges every clock, including random vectors that mix strobes with `cc_en` on and off.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

  localparam int BLK_OFS_W = 3;
  localparam int MAX_LANES = 8;

  typedef enum logic [1:0] {
    ELEM_8   = 2'b00,
    ELEM_16  = 2'b01,
    ELEM_32  = 2'b10,
    ELEM_RSV = 2'b11
  } elem_size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  // all-ones pattern covering the active lanes
  function automatic logic [MAX_LANES-1:0] lane_full(int lanes);
    return MAX_LANES'((9'h1 << lanes) - 9'h1);
  endfunction

  // lanes from the addressed element up to the end of the block
  function automatic logic [MAX_LANES-1:0] start_mask(int lanes, int idx, logic little);
    logic [MAX_LANES-1:0] full;
    full = lane_full(lanes);
    if (little) return (full << idx) & full;
    return full >> idx;
  endfunction

  // lanes from the start of the block up to the addressed element
  function automatic logic [MAX_LANES-1:0] end_mask(int lanes, int idx, logic little);
    logic [MAX_LANES-1:0] full;
    full = lane_full(lanes);
    if (little) return full >> (lanes - 1 - idx);
    return (full << (lanes - 1 - idx)) & full;
  endfunction

endpackage

// File: rtl/edge_mask_table.sv
module edge_mask_table
  import edge_mask_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [BLK_OFS_W-1:0] ofs_a,
  input  logic [BLK_OFS_W-1:0] ofs_b,
  input  logic                 little,
  output logic [MAX_LANES-1:0] left_m,
  output logic [MAX_LANES-1:0] right_m
);
  localparam int SHIFT = BLK_OFS_W - $clog2(LANES);

  logic [BLK_OFS_W-1:0] idx_a, idx_b;

  always_comb begin
    idx_a   = ofs_a >> SHIFT;
    idx_b   = ofs_b >> SHIFT;
    left_m  = start_mask(LANES, int'(idx_a), little);
    right_m = end_mask(LANES, int'(idx_b), little);
  end

  always_comb begin
    if (!$isunknown(ofs_a)) AST_LEFT_NONEMPTY: assert (left_m != '0); // R1
    if (!$isunknown(ofs_b)) AST_RIGHT_NONEMPTY: assert (right_m != '0); // R2
  end
endmodule

// File: rtl/edge_block_cmp.sv
module edge_block_cmp
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              addr32,
  output logic              same_block
);
  logic [ADDR_W-1:0] a_eff, b_eff;

  always_comb begin
    a_eff = addr_a;
    b_eff = addr_b;
    if (addr32) begin
      a_eff[ADDR_W-1:32] = '0;
      b_eff[ADDR_W-1:32] = '0;
    end
    same_block = (a_eff[ADDR_W-1:BLK_OFS_W] == b_eff[ADDR_W-1:BLK_OFS_W]);
  end
endmodule

// File: rtl/edge_cc_calc.sv
module edge_cc_calc
  import edge_mask_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output flags_t       flags
);
  logic [W:0] diff;

  always_comb begin
    diff    = {1'b0, op_a} - {1'b0, op_b};
    flags.n = diff[W-1];
    flags.z = (diff[W-1:0] == '0);
    flags.v = (op_a[W-1] ^ op_b[W-1]) & (diff[W-1] ^ op_a[W-1]);
    flags.c = diff[W];
  end

  always_comb begin
    if (flags.z === 1'b1) AST_ZERO_NO_BORROW: assert (flags.c == 1'b0 && flags.v == 1'b0); // R7
  end
endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
  import edge_mask_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OUT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [1:0]        elem_size,
  input  logic              little_end,
  input  logic              cc_en,
  input  logic              addr32,
  output logic              out_valid,
  output logic [OUT_W-1:0]  mask_out,
  output logic              cc_valid,
  output logic [3:0]        cc_icc,
  output logic [3:0]        cc_xcc
);
  localparam int N_SIZES = 3;

  logic [MAX_LANES-1:0] left_by  [N_SIZES];
  logic [MAX_LANES-1:0] right_by [N_SIZES];
  logic [MAX_LANES-1:0] left_w, right_w, comb_mask;
  logic                 same_block_w;
  logic                 cc_strobe_w;
  flags_t               icc_w, xcc_w;
  elem_size_e           size_e;

  genvar g;
  generate
    for (g = 0; g < N_SIZES; g++) begin : g_size
      edge_mask_table #(.LANES(MAX_LANES >> g)) u_tab (
        .ofs_a  (addr_a[BLK_OFS_W-1:0]),
        .ofs_b  (addr_b[BLK_OFS_W-1:0]),
        .little (little_end),
        .left_m (left_by[g]),
        .right_m(right_by[g])
      );
    end
  endgenerate

  edge_block_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr_a    (addr_a),
    .addr_b    (addr_b),
    .addr32    (addr32),
    .same_block(same_block_w)
  );

  edge_cc_calc #(.W(32)) u_cc32 (
    .op_a (addr_a[31:0]),
    .op_b (addr_b[31:0]),
    .flags(icc_w)
  );

  edge_cc_calc #(.W(ADDR_W)) u_cc64 (
    .op_a (addr_a),
    .op_b (addr_b),
    .flags(xcc_w)
  );

  always_comb begin
    size_e = elem_size_e'(elem_size);
    unique case (size_e)
      ELEM_16: begin left_w = left_by[1]; right_w = right_by[1]; end
      ELEM_32: begin left_w = left_by[2]; right_w = right_by[2]; end
      default: begin left_w = left_by[0]; right_w = right_by[0]; end
    endcase
    comb_mask   = same_block_w ? (left_w & right_w) : left_w;
    cc_strobe_w = in_valid & cc_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mask_out  <= '0;
      cc_valid  <= 1'b0;
      cc_icc    <= '0;
      cc_xcc    <= '0;
    end else begin
      out_valid <= in_valid;
      cc_valid  <= cc_strobe_w;
      if (in_valid) mask_out <= OUT_W'(comb_mask);
      if (cc_strobe_w) begin
        cc_icc <= icc_w;
        cc_xcc <= xcc_w;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_CC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> (out_valid && $past(cc_en))); // R8
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_strobe_w |=> ($stable(cc_icc) && $stable(cc_xcc))); // R8
  AST_SUBSET_OF_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((mask_out[MAX_LANES-1:0] & ~$past(left_w)) == '0)); // R5
  AST_OTHER_BLOCK_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !same_block_w) |=> (mask_out[MAX_LANES-1:0] == $past(left_w))); // R5
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mask_out[OUT_W-1:MAX_LANES] == '0)); // R9
endmodule

// File: tb/tb_edge_mask_unit.sv
module tb_edge_mask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] addr_a = '0, addr_b = '0;
  logic [1:0]  elem_size = '0;
  logic        little_end = 1'b0, cc_en = 1'b0, addr32 = 1'b0;
  logic        out_valid, cc_valid;
  logic [63:0] mask_out;
  logic [3:0]  cc_icc, cc_xcc;

  int n_checks = 0, n_fail = 0;
  logic [7:0] m_mask = '0;
  logic [3:0] m_icc = '0, m_xcc = '0;

  always #10 clk = ~clk;

  edge_mask_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr_a(addr_a), .addr_b(addr_b),
    .elem_size(elem_size), .little_end(little_end), .cc_en(cc_en), .addr32(addr32),
    .out_valid(out_valid), .mask_out(mask_out), .cc_valid(cc_valid),
    .cc_icc(cc_icc), .cc_xcc(cc_xcc)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // lane p counted from the block start; big-endian puts lane 0 in the top bit
  function automatic logic [7:0] ref_mask(logic [63:0] a, logic [63:0] b,
                                          logic [1:0] sz, logic le, logic a32);
    int n, per, ka, kb, pos;
    logic [7:0] lm, rm;
    logic same;
    n   = (sz == 2'b01) ? 4 : (sz == 2'b10) ? 2 : 8;
    per = 8 / n;
    ka  = int'(a[2:0]) / per;
    kb  = int'(b[2:0]) / per;
    lm = '0; rm = '0;
    for (int p = 0; p < n; p++) begin
      pos = le ? p : n - 1 - p;
      if (p >= ka) lm[pos] = 1'b1;
      if (p <= kb) rm[pos] = 1'b1;
    end
    same = a32 ? (a[31:3] == b[31:3]) : (a[63:3] == b[63:3]);
    return same ? (lm & rm) : lm;
  endfunction

  function automatic logic [3:0] ref_flags(logic [63:0] a, logic [63:0] b, int w);
    logic signed [64:0] sa, sb, t;
    logic [63:0] ua, ub, d;
    logic n, z, v, c;
    if (w == 32) begin
      ua = {32'd0, a[31:0]}; ub = {32'd0, b[31:0]};
      sa = {{33{a[31]}}, a[31:0]}; sb = {{33{b[31]}}, b[31:0]};
      t = sa - sb;
      d = ua - ub;
      n = d[31]; z = (d[31:0] == 0);
      v = (t > 65'sd2147483647) || (t < -65'sd2147483648);
    end else begin
      ua = a; ub = b;
      sa = {a[63], a}; sb = {b[63], b};
      t = sa - sb;
      d = ua - ub;
      n = d[63]; z = (d == 0);
      v = (t[64] != t[63]);
    end
    c = (ua < ub);
    return {n, z, v, c};
  endfunction

  // one clock: drive after the edge, update the model, sample 2 ns after the next edge
  task automatic step(logic v, logic [63:0] a, logic [63:0] b, logic [1:0] sz,
                      logic le, logic ce, logic a32, string tag);
    in_valid = v; addr_a = a; addr_b = b; elem_size = sz;
    little_end = le; cc_en = ce; addr32 = a32;
    @(posedge clk);
    if (v) m_mask = ref_mask(a, b, sz, le, a32);
    if (v && ce) begin
      m_icc = ref_flags(a, b, 32);
      m_xcc = ref_flags(a, b, 64);
    end
    #2;
    check("R9 out_valid", {63'd0, out_valid}, {63'd0, v});
    check(tag, mask_out, {56'd0, m_mask});
    check("R8 cc_valid", {63'd0, cc_valid}, {63'd0, v & ce});
    check("R7 cc_icc", {60'd0, cc_icc}, {60'd0, m_icc});
    check("R7 cc_xcc", {60'd0, cc_xcc}, {60'd0, m_xcc});
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    repeat (3) @(posedge clk);
    #2;
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 mask_out", mask_out, 64'd0);
    check("R10 cc_valid", {63'd0, cc_valid}, 64'd0);
    check("R10 flags", {56'd0, cc_icc, cc_xcc}, 64'd0);
    rst_n = 1'b1;

    // R1 big-endian bytes, distinct blocks then same block; code 11 acts as 8-bit
    for (int k = 0; k < 8; k++) step(1, 64'h100 + k, 64'h200 + k, 2'b00, 0, 0, 0, "R1 mask");
    for (int k = 0; k < 8; k++) step(1, 64'h100, 64'h100 + k, 2'b00, 0, 0, 0, "R1 end mask");
    step(1, 64'h103, 64'h106, 2'b11, 0, 0, 0, "R1 mask code11");
    // R2 little-endian bytes
    for (int k = 0; k < 8; k++) step(1, 64'h100 + k, 64'h300, 2'b00, 1, 0, 0, "R2 mask");
    for (int k = 0; k < 8; k++) step(1, 64'h100, 64'h100 + k, 2'b00, 1, 0, 0, "R2 end mask");
    // R3 halfwords, R4 words, both orders
    for (int k = 0; k < 8; k++) begin
      step(1, 64'h40 + k, 64'h80 + k, 2'b01, 0, 0, 0, "R3 mask BE");
      step(1, 64'h40, 64'h40 + k, 2'b01, 1, 0, 0, "R3 mask LE");
      step(1, 64'h40 + k, 64'h40 + 7, 2'b10, 0, 0, 0, "R4 mask BE");
      step(1, 64'h40, 64'h40 + k, 2'b10, 1, 0, 0, "R4 mask LE");
    end
    // R5 same block intersection vs neighbouring block
    step(1, 64'h1002, 64'h1005, 2'b00, 0, 0, 0, "R5 same block");
    step(1, 64'h1002, 64'h1008, 2'b00, 0, 0, 0, "R5 next block");
    // R6 with R7 in the same cycle: upper words differ, lower words share a block
    step(1, 64'h0000_0001_0000_0012, 64'h0000_0000_0000_0014, 2'b00, 0, 1, 1, "R6 truncated same");
    step(1, 64'h0000_0001_0000_0012, 64'h0000_0000_0000_0014, 2'b00, 0, 1, 0, "R6 untruncated");
    step(1, 64'h0000_0001_0000_0010, 64'h0000_0000_0000_0010, 2'b00, 0, 1, 1, "R7 icc zero xcc not");
    step(1, 64'h8000_0000_0000_0000, 64'd1, 2'b00, 0, 1, 0, "R7 overflow");
    step(1, 64'd1, 64'd2, 2'b00, 0, 1, 0, "R7 borrow");
    // R8 strobe without flag enable keeps flags; idle cycles hold the mask
    step(1, 64'd5, 64'd9, 2'b00, 0, 0, 0, "R8 hold flags");
    step(0, 64'hFFFF, 64'h0, 2'b00, 1, 1, 0, "R9 idle hold");
    step(0, 64'h0, 64'h0, 2'b00, 0, 0, 0, "R9 idle hold");
    // random mix
    for (int i = 0; i < 400; i++) begin
      ra = {$urandom, $urandom};
      rb = (i % 2 == 0) ? {ra[63:3], 3'($urandom)} : {$urandom, $urandom};
      if (i % 5 == 0) rb[63:32] = $urandom;
      step(1'($urandom % 4 != 0), ra, rb, 2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), "R5 random mask");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule